// File: doc/BRIEF.md
# Bit-Test Execution Unit

This unit carries out one family of bit-test instructions inside a small nibble-wide accumulator datapath. It holds two 4-bit data registers, called A and B, and two 16-bit index registers, called X and Y. When a qualified opcode arrives, the unit places an address on a synchronous read port. It takes the returned nibble in the same cycle and ANDs it with the chosen data register. Only the zero flag records the outcome. The data register is never changed.

Two options widen the basic test. A post-increment variant advances the chosen index register once the access is done. A one-shot extension prefix is armed by a strobe that carries an 8-bit immediate. For the next instruction only, it replaces the index address with a page-anchored address: the bottom page when X is chosen, the top page when Y is chosen. The rest of the datapath loads the four registers through a plain write port.

Top module: `bittest_exec_unit`

## Requirements
- R1: An opcode is legal only when `instr_valid` is 1 and `instr_code[12:3]` equals 10'b1101011100, which gives the codes 0x1AE0 to 0x1AE7. For a legal opcode, bit 2 selects the data register (0 = A, 1 = B), bit 1 selects the index register (0 = X, 1 = Y) and bit 0 requests post-increment (1 = increment).
- R2: During a legal opcode, `mem_rd` is 1 and `mem_addr` carries the selected index register in the same cycle, unless R6 applies. During any other cycle, `mem_rd` is 0.
- R3: After the clock edge that ends a legal opcode, `zero_flag` is 1 if `mem_rdata` AND the selected data register equals 0, and 0 otherwise. Any other cycle leaves `zero_flag` unchanged.
- R4: The bit test never changes A or B.
- R5: In the post-increment form, the selected index register gains one at the clock edge and wraps from 0xFFFF to 0x0000. The other index register and the flag are not disturbed by the increment.
- R6: Suppose an extension is pending and a legal non-increment opcode arrives. With X selected, the address is 0x0000 + imm8. With Y selected, the address is 0xFF00 + imm8.
- R7: A post-increment opcode ignores a pending extension and uses the plain index address. It still consumes the extension.
- R8: A pulse on `ext_load` arms the extension with `ext_imm`. The next `instr_valid` cycle clears it, whether the opcode is legal or not. If `ext_load` and `instr_valid` occur in the same cycle, the instruction sees the earlier extension state, and the new extension is armed for the instruction that follows.
- R9: An illegal opcode with `instr_valid` at 1 changes no register and no flag. It raises `illegal_op` for exactly the cycle that follows.
- R10: A synchronous active-high `rst` clears A, B, X, Y, `zero_flag`, `illegal_op` and the pending extension.
- R11: When `wr_en` is 1, the register given by `wr_sel` (0 = A, 1 = B, 2 = X, 3 = Y) takes `wr_data` at the clock edge; A and B take the low 4 bits. A write overrides a post-increment of the same index register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr_code` for this cycle |
| instr_code | input | 13 | Opcode under execution |
| ext_load | input | 1 | One-cycle strobe that arms the extension |
| ext_imm | input | 8 | Immediate captured by `ext_load` |
| wr_en | input | 1 | Register write strobe from the datapath |
| wr_sel | input | 2 | Write target: 0 A, 1 B, 2 X, 3 Y |
| wr_data | input | 16 | Write value (A and B use bits 3:0) |
| mem_rd | output | 1 | Data-memory read request |
| mem_addr | output | 16 | Data-memory address |
| mem_rdata | input | 4 | Read data returned in the same cycle |
| zero_flag | output | 1 | Zero flag |
| illegal_op | output | 1 | Pulses the cycle after an illegal opcode |
| reg_a | output | 4 | Data register A |
| reg_b | output | 4 | Data register B |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |

## Verification
Arming the extension and executing an instruction can fall in the same cycle. So can a register write and a post-increment of the same index register. The bench provokes both, first in directed steps and then from a random stream in which strobes overlap freely. A behavioural model predicts every address, flag and register on every clock. That model decides whether the colliding instruction used the old extension state and whether the write won over the increment.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int OPC_W = 13;
    localparam logic [9:0] BT_FAMILY = 10'b1101011100;

    typedef struct packed {
        logic legal;
        logic illegal;
        logic use_b;
        logic use_y;
        logic post_inc;
    } bt_dec_t;

    typedef enum logic [1:0] {
        WSEL_A = 2'd0,
        WSEL_B = 2'd1,
        WSEL_X = 2'd2,
        WSEL_Y = 2'd3
    } wsel_e;
endpackage

// File: rtl/bt_decoder.sv
module bt_decoder
    import bt_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] code,
    output bt_dec_t          dec
);
    logic family_hit;

    always_comb begin
        family_hit   = (code[OPC_W-1:3] == BT_FAMILY);
        dec.legal    = valid && family_hit;
        dec.illegal  = valid && !family_hit;
        dec.use_b    = code[2];
        dec.use_y    = code[1];
        dec.post_inc = code[0];
    end
endmodule

// File: rtl/bt_addr_gen.sv
module bt_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] idx_x,
    input  logic [ADDR_W-1:0] idx_y,
    input  logic              use_y,
    input  logic              post_inc,
    input  logic              ext_pend,
    input  logic [IMM_W-1:0]  ext_imm,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAGE_W = ADDR_W - IMM_W;

    logic [PAGE_W-1:0] page;
    logic              ext_used;

    always_comb begin
        page     = use_y ? {PAGE_W{1'b1}} : {PAGE_W{1'b0}};
        ext_used = ext_pend && !post_inc;
        if (ext_used)
            addr = {page, ext_imm};
        else
            addr = use_y ? idx_y : idx_x;
    end

    // R6
    ext_page_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_pend && !post_inc) |-> (addr[IMM_W-1:0] == ext_imm));

    // R7
    inc_plain_chk: assert property (@(posedge clk) disable iff (rst)
        post_inc |-> (addr == (use_y ? idx_y : idx_x)));
endmodule

// File: rtl/bt_index_next.sv
module bt_index_next #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (wr)
            nxt = wdata;
        else if (inc)
            nxt = cur + W'(1);
        else
            nxt = cur;
    end
endmodule

// File: rtl/bittest_exec_unit.sv
module bittest_exec_unit
    import bt_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  instr_code,
    input  logic              ext_load,
    input  logic [IMM_W-1:0]  ext_imm,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              zero_flag,
    output logic              illegal_op,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_b,
    output logic [ADDR_W-1:0] reg_x,
    output logic [ADDR_W-1:0] reg_y
);
    localparam int NIDX = 2;

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [ADDR_W-1:0] x;
        logic [ADDR_W-1:0] y;
        logic              z;
        logic              ill;
        logic              pend;
        logic [IMM_W-1:0]  imm;
    } st_t;

    st_t st_d, st_q;
    bt_dec_t dec;
    logic [DATA_W-1:0] test_val;
    logic [ADDR_W-1:0] idx_cur [NIDX];
    logic [ADDR_W-1:0] idx_nxt [NIDX];

    bt_decoder u_dec (
        .valid (instr_valid),
        .code  (instr_code),
        .dec   (dec)
    );

    bt_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .idx_x    (st_q.x),
        .idx_y    (st_q.y),
        .use_y    (dec.use_y),
        .post_inc (dec.post_inc),
        .ext_pend (st_q.pend),
        .ext_imm  (st_q.imm),
        .addr     (mem_addr)
    );

    assign idx_cur[0] = st_q.x;
    assign idx_cur[1] = st_q.y;

    for (genvar gi = 0; gi < NIDX; gi++) begin : g_idx
        localparam logic [1:0] SEL = (gi == 0) ? WSEL_X : WSEL_Y;
        logic hit_inc;
        logic hit_wr;
        assign hit_inc = dec.legal && dec.post_inc && (dec.use_y == (gi == 1));
        assign hit_wr  = wr_en && (wr_sel == SEL);
        bt_index_next #(.W(ADDR_W)) u_nxt (
            .cur   (idx_cur[gi]),
            .inc   (hit_inc),
            .wr    (hit_wr),
            .wdata (wr_data),
            .nxt   (idx_nxt[gi])
        );
    end

    assign mem_rd = dec.legal;

    always_comb begin
        st_d     = st_q;
        test_val = (dec.use_b ? st_q.b : st_q.a) & mem_rdata;

        if (dec.legal)
            st_d.z = (test_val == '0);
        st_d.ill = dec.illegal;

        st_d.x = idx_nxt[0];
        st_d.y = idx_nxt[1];
        if (wr_en && wr_sel == WSEL_A)
            st_d.a = wr_data[DATA_W-1:0];
        if (wr_en && wr_sel == WSEL_B)
            st_d.b = wr_data[DATA_W-1:0];

        if (ext_load) begin
            st_d.pend = 1'b1;
            st_d.imm  = ext_imm;
        end else if (instr_valid) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign zero_flag  = st_q.z;
    assign illegal_op = st_q.ill;
    assign reg_a      = st_q.a;
    assign reg_b      = st_q.b;
    assign reg_x      = st_q.x;
    assign reg_y      = st_q.y;

    // R2
    no_rd_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (!instr_valid || instr_code[OPC_W-1:3] != BT_FAMILY) |-> !mem_rd);

    // R3
    z_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rd |=> $stable(zero_flag));

    // R4
    data_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(reg_a) && $stable(reg_b)));

    // R5
    x_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && instr_code[0] && !instr_code[1] && !wr_en)
        |=> (reg_x == $past(reg_x) + ADDR_W'(1)) && $stable(reg_y));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !ext_load) |=> !st_q.pend);

    // R9
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_code[OPC_W-1:3] != BT_FAMILY && !wr_en)
        |=> (illegal_op && $stable(reg_x) && $stable(reg_y) && $stable(zero_flag)));

    // R11
    wr_over_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == WSEL_Y) |=> (reg_y == $past(wr_data)));
endmodule

// File: tb/bittest_exec_unit_tb.sv
module bittest_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [12:0] instr_code;
    logic        ext_load;
    logic [7:0]  ext_imm;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [3:0]  mem_rdata;
    logic        zero_flag;
    logic        illegal_op;
    logic [3:0]  reg_a;
    logic [3:0]  reg_b;
    logic [15:0] reg_x;
    logic [15:0] reg_y;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    int m_a, m_b, m_x, m_y, m_z, m_ill, m_pend, m_imm;

    always #5 clk = ~clk;

    function automatic logic [3:0] memf(input logic [15:0] ad);
        return ad[3:0] ^ ad[7:4] ^ ad[11:8] ^ ad[15:12] ^ 4'h6;
    endfunction

    assign mem_rdata = memf(mem_addr);

    bittest_exec_unit u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_code(instr_code),
        .ext_load(ext_load), .ext_imm(ext_imm), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .zero_flag(zero_flag), .illegal_op(illegal_op), .reg_a(reg_a), .reg_b(reg_b),
        .reg_x(reg_x), .reg_y(reg_y)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        instr_valid = 0; instr_code = '0; ext_load = 0; ext_imm = '0;
        wr_en = 0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic check_regs();
        chk("R3 zero_flag", int'(zero_flag), m_z);
        chk("R4 reg_a", int'(reg_a), m_a);
        chk("R4 reg_b", int'(reg_b), m_b);
        chk("R5 reg_x", int'(reg_x), m_x);
        chk("R5 reg_y", int'(reg_y), m_y);
        chk("R9 illegal_op", int'(illegal_op), m_ill);
    endtask

    task automatic step(input bit v, input int code, input bit el, input int imm,
                        input bit we, input int ws, input int wd);
        bit legal, iy, ib, pinc;
        int addr, res, nx, ny;
        @(negedge clk);
        instr_valid = v; instr_code = 13'(code); ext_load = el; ext_imm = 8'(imm);
        wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
        #1;
        legal = v && ((code >> 3) == 'h35C);
        iy = code[1]; ib = code[2]; pinc = code[0];
        if (m_pend != 0 && !pinc)
            addr = iy ? ('hFF00 | m_imm) : m_imm;
        else
            addr = iy ? m_y : m_x;
        chk("R1 R2 mem_rd", int'(mem_rd), int'(legal));
        if (legal) chk("R2 R6 R7 mem_addr", int'(mem_addr), addr);
        res = (ib ? m_b : m_a) & int'(memf(16'(addr)));
        nx = m_x; ny = m_y;
        if (legal) begin
            m_z = (res == 0) ? 1 : 0;
            if (pinc && !iy) nx = (m_x + 1) & 'hFFFF;
            if (pinc && iy)  ny = (m_y + 1) & 'hFFFF;
        end
        if (we) begin
            if (ws == 0) m_a = wd & 'hF;
            if (ws == 1) m_b = wd & 'hF;
            if (ws == 2) nx = wd & 'hFFFF;
            if (ws == 3) ny = wd & 'hFFFF;
        end
        m_x = nx; m_y = ny;
        m_ill = (v && !legal) ? 1 : 0;
        if (el) begin m_pend = 1; m_imm = imm & 'hFF; end
        else if (v) m_pend = 0;
        @(posedge clk);
        #1;
        check_regs();
    endtask

    task automatic wr(input int ws, input int wd);
        step(0, 0, 0, 0, 1, ws, wd);
    endtask

    task automatic ins(input int code);
        step(1, code, 0, 0, 0, 0, 0);
    endtask

    task automatic ext(input int imm);
        step(0, 0, 1, imm, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_z = 0; m_ill = 0; m_pend = 0; m_imm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R10 reset state
        check_regs();
        chk("R10 mem_rd idle", int'(mem_rd), 0);

        // R11 register loads
        wr(0, 'h5); wr(1, 'hA); wr(2, 'h0010); wr(3, 'hFFFF);
        // R1 R3 plain tests, both data regs and both index regs
        ins('h1AE0); ins('h1AE6); ins('h1AE2); ins('h1AE4);
        // R5 post-increment, Y wraps to zero
        ins('h1AE7); ins('h1AE1); ins('h1AE3);
        // R6 extension with X and Y
        ext('h3C); ins('h1AE0);
        ext('h81); ins('h1AE6);
        // R6 extension lasts one instruction only
        ext('h22); ins('h1AE2); ins('h1AE2);
        // R7 post-increment ignores a pending extension
        ext('h55); ins('h1AE5); ins('h1AE0);
        // R8 illegal opcode consumes the extension
        ext('h77); ins('h0AE0); ins('h1AE0);
        // R8 arm and execute in the same cycle
        ext('h10); step(1, 'h1AE2, 1, 'h99, 0, 0, 0); ins('h1AE2);
        // R9 codes just outside the family, and a valid-low legal code
        ins('h1AE8); ins('h1ADF); step(0, 'h1AE1, 0, 0, 0, 0, 0);
        // R11 write beats increment on same index register
        step(1, 'h1AE1, 0, 0, 1, 2, 'h1234);
        step(1, 'h1AE3, 0, 0, 1, 3, 'hBEEF);
        // R4 data register write during a test
        step(1, 'h1AE4, 0, 0, 1, 1, 'h3);

        // random stream
        for (int i = 0; i < 4000; i++) begin
            int code;
            if ($urandom % 10 < 7) code = 'h1AE0 | int'($urandom % 8);
            else code = int'($urandom % 8192);
            step(($urandom % 5) != 0, code, ($urandom % 5) == 0, int'($urandom % 256),
                 ($urandom % 7) == 0, int'($urandom % 4), int'($urandom % 65536));
            if (i == 2000) begin
                @(negedge clk);
                idle_inputs();
                rst = 1;
                @(posedge clk);
                #1;
                rst = 0;
                m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_z = 0; m_ill = 0; m_pend = 0; m_imm = 0;
                check_regs();
            end
        end
        @(negedge clk);
        idle_inputs();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule